// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Time Insertion

This block is one channel of a motor-control pulse-width generator. A free-running counter sweeps between zero and a programmed period value, either as a sawtooth (edge-aligned) or as a triangle (center-aligned). A compare stage turns the counter position and a programmed pulse-width value into a request for output A to be active. Output B requests the opposite state. Each output passes through its own dead-time stage, which holds back a passive-to-active change by a programmed number of clocks and passes an active-to-passive change straight on. The two outputs therefore never drive both switches of a half-bridge at once.

A polarity bit decides whether "active" means a high or a low pin level. Software sets up the channel through a plain write port: a write enable, a two-bit address and a 16-bit data word. A stopped channel holds its counter at zero and parks the outputs in their reset states.

Top module: `mcpwm_channel`

## Requirements
- R1: While reset is asserted, and after reset with no writes, pwm_a is low (A passive) and pwm_b is high (B active).
- R2: In edge-aligned mode (control bit 1 = 0) the counter steps 0, 1, ..., limit and then restarts at 0. The period is limit+1 clocks. A is active while match <= count < limit, which gives limit-match active clocks per period.
- R3: In center-aligned mode (control bit 1 = 1) the counter rises from 0 to limit and falls back to 0, so the period is 2*limit clocks. A goes active when the count reaches match on the way up and goes passive when the count reaches match on the way down, which gives 2*(limit-match) active clocks per period.
- R4: With dead-time disabled, B is active in exactly the clocks in which A is passive.
- R5: With dead-time enabled (control bit 3 = 1), each passive-to-active change of either output is delayed by the dead-time count, in clocks. Active-to-passive changes are not delayed, and A and B are never active in the same clock.
- R6: A request to go active that is withdrawn before the dead-time count has run out is cancelled, so the output stays passive.
- R7: With dead-time disabled, the value held in the dead-time count register has no effect on the outputs.
- R8: Control bit 2 selects polarity. When it is 0, active is driven as a high level. When it is 1, active is driven as a low level and passive as a high level.
- R9: A match value of 0 keeps A active for the whole period. A match value equal to or above the limit keeps A passive for the whole period.
- R10: With the run bit (control bit 0) clear, the counter holds at 0, A is held passive and B is held active, at the selected polarity. No dead-time delay applies while the channel is stopped.
- R11: A write takes place on a clock edge where wr_en is high. The address selects the register: 0 is control (bit 0 run, bit 1 center-aligned, bit 2 polarity, bit 3 dead-time enable), 1 is limit, 2 is match, and 3 is the dead-time count (the low 8 bits of the data word).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | Output A pin level |
| pwm_b | output | 1 | Output B pin level |

## Verification
The bench builds the block with its default widths: a 16-bit counter and an 8-bit dead-time count. It programs small values, such as a limit of 8 or 9, a match of 3 and dead-times of 2 and 5. With these values a whole period is only 10 to 16 clocks, so each scenario settles quickly and can be measured over several whole periods by counting active clocks on each pin. The dead-time of 5 is longer than B's active window, which exercises cancellation. Setting match to 0, to the limit and above the limit covers the compare boundaries.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
    parameter int CNT_W  = 16;
    parameter int DT_W   = 8;
    parameter int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_LIM  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_MAT  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADR_DT   = ADDR_W'(3);

    localparam int BIT_RUN = 0;
    localparam int BIT_CTR = 1;
    localparam int BIT_POL = 2;
    localparam int BIT_DTE = 3;

    typedef struct packed {
        logic             run;
        logic             center;
        logic             pol;
        logic             dt_en;
        logic [CNT_W-1:0] lim;
        logic [CNT_W-1:0] mat;
        logic [DT_W-1:0]  dt;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
    } ctr_t;

    typedef struct packed {
        logic            act;
        logic [DT_W-1:0] wait_cnt;
    } dt_t;
endpackage

// File: rtl/mcpwm_regs.sv
module mcpwm_regs
    import mcpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    cfg_d.run    = wr_data[BIT_RUN];
                    cfg_d.center = wr_data[BIT_CTR];
                    cfg_d.pol    = wr_data[BIT_POL];
                    cfg_d.dt_en  = wr_data[BIT_DTE];
                end
                ADR_LIM: cfg_d.lim = wr_data;
                ADR_MAT: cfg_d.mat = wr_data;
                default: cfg_d.dt  = wr_data[DT_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/mcpwm_counter.sv
module mcpwm_counter
    import mcpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    output logic [CNT_W-1:0] cnt,
    output logic             up
);
    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (!cfg.run) begin
            ctr_d.cnt = '0;
            ctr_d.up  = 1'b1;
        end else if (!cfg.center) begin
            ctr_d.up  = 1'b1;
            ctr_d.cnt = (ctr_q.cnt >= cfg.lim) ? '0 : ctr_q.cnt + 1'b1;
        end else if (ctr_q.up) begin
            if (ctr_q.cnt >= cfg.lim) begin
                if (ctr_q.cnt != '0) begin
                    ctr_d.up  = 1'b0;
                    ctr_d.cnt = ctr_q.cnt - 1'b1;
                end
            end else begin
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
        end else begin
            if (ctr_q.cnt == '0) begin
                if (cfg.lim != '0) begin
                    ctr_d.up  = 1'b1;
                    ctr_d.cnt = ctr_q.cnt + 1'b1;
                end
            end else begin
                ctr_d.cnt = ctr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q.cnt <= '0;
            ctr_q.up  <= 1'b1;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt = ctr_q.cnt;
    assign up  = ctr_q.up;
endmodule

// File: rtl/mcpwm_compare.sv
module mcpwm_compare
    import mcpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic             up,
    output logic             a_req
);
    logic req_d, req_q;
    logic in_win;

    always_comb begin
        if (cfg.center) in_win = up ? (cnt >= cfg.mat) : (cnt > cfg.mat);
        else            in_win = (cnt >= cfg.mat) && (cnt < cfg.lim);
        req_d = cfg.run && ((cfg.mat == '0) || ((cfg.mat < cfg.lim) && in_win));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign a_req = req_q;
endmodule

// File: rtl/mcpwm_deadtime.sv
module mcpwm_deadtime
    import mcpwm_pkg::*;
#(
    parameter logic RST_ACT = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            bypass,
    input  logic [DT_W-1:0] dt,
    output logic            act
);
    dt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!req) begin
            st_d.act      = 1'b0;
            st_d.wait_cnt = '0;
        end else if (!st_q.act) begin
            if (bypass || (st_q.wait_cnt >= dt)) begin
                st_d.act      = 1'b1;
                st_d.wait_cnt = '0;
            end else begin
                st_d.wait_cnt = st_q.wait_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act      <= RST_ACT;
            st_q.wait_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act = st_q.act;
endmodule

// File: rtl/mcpwm_channel.sv
module mcpwm_channel
    import mcpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);
    localparam int NUM_OUT = 2;

    cfg_t             cfg;
    logic [CNT_W-1:0] cnt_w;
    logic             up_w;
    logic             a_req_w;
    logic [NUM_OUT-1:0] req_w;
    logic [NUM_OUT-1:0] act_w;
    logic             run_w, center_w, pol_w, bypass_w;
    logic [CNT_W-1:0] lim_w;

    assign run_w    = cfg.run;
    assign center_w = cfg.center;
    assign pol_w    = cfg.pol;
    assign lim_w    = cfg.lim;
    assign bypass_w = !cfg.dt_en || !cfg.run;

    mcpwm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg)
    );

    mcpwm_counter u_ctr (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .cnt(cnt_w), .up(up_w)
    );

    mcpwm_compare u_cmp (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .cnt(cnt_w), .up(up_w), .a_req(a_req_w)
    );

    assign req_w[0] = run_w && a_req_w;
    assign req_w[1] = run_w ? !a_req_w : 1'b1;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_dt
        mcpwm_deadtime #(.RST_ACT(i == 1)) u_dt (
            .clk(clk), .rst_n(rst_n), .req(req_w[i]),
            .bypass(bypass_w), .dt(cfg.dt), .act(act_w[i])
        );
    end

    assign pwm_a = act_w[0] ^ pol_w;
    assign pwm_b = act_w[1] ^ pol_w;
endmodule

// File: rtl/mcpwm_channel_chk.sv
module mcpwm_channel_chk
    import mcpwm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             center,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim,
    input logic [1:0]       req,
    input logic [1:0]       act
);
    // R5
    never_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(act[0] && act[1]));

    // R5
    a_fall_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req[0] |=> !act[0]);

    // R5
    b_fall_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req[1] |=> !act[1]);

    // R2
    edge_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!center && cnt >= lim) |=> (cnt == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= lim) |=> (cnt <= $past(lim)));

    // R10
    stop_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!act[0] && act[1] && cnt == '0));
endmodule

bind mcpwm_channel mcpwm_channel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_w), .center(center_w),
    .cnt(cnt_w), .lim(lim_w), .req(req_w), .act(act_w)
);

// File: tb/sim_mcpwm_channel.sv
module sim_mcpwm_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mcpwm_channel u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int ctrl, input int lim, input int mat, input int dt);
        wr(2'd1, 16'(lim));
        wr(2'd2, 16'(mat));
        wr(2'd3, 16'(dt));
        wr(2'd0, 16'(ctrl));
        repeat (60) @(negedge clk);
    endtask

    task automatic measure(input int cycles, output int ah, output int bh, output int both);
        ah = 0; bh = 0; both = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_a) ah++;
            if (pwm_b) bh++;
            if (pwm_a && pwm_b) both++;
        end
    endtask

    task automatic t_reset();
        check("R1", "pwm_a in reset", int'(pwm_a), 0);
        check("R1", "pwm_b in reset", int'(pwm_b), 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1", "pwm_a after reset", int'(pwm_a), 0);
        check("R1", "pwm_b after reset", int'(pwm_b), 1);
    endtask

    task automatic t_edge();
        int ah, bh, bo;
        setup(32'h1, 9, 3, 0);
        measure(40, ah, bh, bo);
        check("R2", "edge A active", ah, 24);
        check("R4", "edge B active", bh, 16);
        check("R4", "edge overlap", bo, 0);
    endtask

    task automatic t_center();
        int ah, bh, bo;
        setup(32'h3, 8, 3, 0);
        measure(64, ah, bh, bo);
        check("R3", "center A active", ah, 40);
        check("R4", "center B active", bh, 24);
    endtask

    task automatic t_dead();
        int ah, bh, bo;
        setup(32'h9, 9, 3, 2);
        measure(40, ah, bh, bo);
        check("R5", "edge dt A active", ah, 16);
        check("R5", "edge dt B active", bh, 8);
        check("R5", "edge dt overlap", bo, 0);
        setup(32'hB, 8, 3, 2);
        measure(64, ah, bh, bo);
        check("R5", "center dt A active", ah, 32);
        check("R5", "center dt B active", bh, 16);
    endtask

    task automatic t_cancel();
        int ah, bh, bo;
        setup(32'h9, 9, 3, 5);
        measure(40, ah, bh, bo);
        check("R6", "cancel A active", ah, 4);
        check("R6", "cancel B active", bh, 0);
    endtask

    task automatic t_dt_off();
        int ah, bh, bo;
        setup(32'h1, 9, 3, 5);
        measure(40, ah, bh, bo);
        check("R7", "dt disabled A active", ah, 24);
        check("R7", "dt disabled B active", bh, 16);
    endtask

    task automatic t_pol();
        int ah, bh, bo;
        setup(32'h5, 9, 3, 0);
        measure(40, ah, bh, bo);
        check("R8", "inverted A high", ah, 16);
        check("R8", "inverted B high", bh, 24);
    endtask

    task automatic t_match();
        int ah, bh, bo;
        setup(32'h1, 9, 0, 0);
        measure(40, ah, bh, bo);
        check("R9", "match 0 A active", ah, 40);
        check("R9", "match 0 B active", bh, 0);
        setup(32'h1, 9, 9, 0);
        measure(40, ah, bh, bo);
        check("R9", "match=limit A active", ah, 0);
        check("R9", "match=limit B active", bh, 40);
        setup(32'h3, 8, 12, 0);
        measure(64, ah, bh, bo);
        check("R9", "match>limit A active", ah, 0);
    endtask

    task automatic t_stop();
        int ah, bh, bo;
        setup(32'h1, 9, 3, 0);
        wr(2'd0, 16'h0);
        repeat (3) @(negedge clk);
        measure(20, ah, bh, bo);
        check("R10", "stopped A high", ah, 0);
        check("R10", "stopped B high", bh, 20);
        wr(2'd0, 16'hC);
        repeat (3) @(negedge clk);
        measure(20, ah, bh, bo);
        check("R10", "stopped inverted A high", ah, 20);
        check("R10", "stopped inverted B high", bh, 0);
        // R11: writes without wr_en must not change registers
        @(negedge clk);
        wr_addr = 2'd0; wr_data = 16'h1;
        repeat (5) @(negedge clk);
        measure(20, ah, bh, bo);
        check("R11", "ignored write A high", ah, 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_edge();
        t_center();
        t_dead();
        t_cancel();
        t_dt_off();
        t_pol();
        t_match();
        t_stop();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule